// File: doc/BRIEF.md
# Synchronous FIFO with Threshold Status Flags

This block is a single-clock first-in first-out buffer whose storage is a simple dual-port array that block RAM can be inferred from. Producers push a word by raising the write strobe, and consumers pop a word by raising the read strobe. The popped word appears on a registered output bus on the clock after the read is taken. Four registered status outputs report the occupancy: nothing stored, at or below a low-water mark, at or above a high-water mark, and no room left. The low-water and high-water marks are parameters, and their order and range are checked when the design is elaborated.

A single selection parameter picks the shape of the array from six fixed depth-by-width options. The depth is 8192 shifted right by the selection, and the width comes from the list 1, 2, 4, 9, 18, 36. The buffer holds at most one word less than the array depth. A synchronous reset clears the pointers, the occupancy, the flags and the output register, but it leaves the array contents alone. A load strobe intended for test can set the occupancy and the write position directly, so that words written before a reset can be read again.

Top module: `thresh_fifo`

## Requirements
- R1: While reset is high at a clock edge, the block returns to the idle state: `is_empty` and `low_water` are 1, `high_water` and `is_full` are 0, and `rd_data` is 0.
- R2: Words leave in the order they arrived. The word for a read taken at a clock edge is on `rd_data` after that edge, and `rd_data` holds its value in every cycle without a taken read.
- R3: A write while `is_full` is 1 is ignored. The occupancy does not change, and the words already stored are returned unchanged later.
- R4: A read while `is_empty` is 1 is ignored. `rd_data` keeps its previous value and the occupancy stays 0.
- R5: A write and a read in the same cycle, with neither blocked, leave the occupancy unchanged. When the FIFO is empty only the write is taken, and when it is full only the read is taken.
- R6: `low_water` is 1 exactly when the occupancy is less than or equal to `LOW_MARK` (default 16).
- R7: `high_water` is 1 exactly when the occupancy is greater than or equal to `HIGH_MARK` (default 240).
- R8: `is_empty` is 1 exactly when the occupancy is 0. `is_full` is 1 exactly when the occupancy equals 2^AW − 1 (255 by default).
- R9: Reset leaves the array contents untouched. A cycle with `tst_load` high sets the occupancy to `tst_count`, the read position to 0 and the write position to `tst_count`, after which the words written before the reset are read back.
- R10: `SHAPE` from 0 to 5 selects a depth of 8192 >> `SHAPE` and a width of 1, 2, 4, 9, 18 or 36. The default of 5 gives 36-bit words and reports full after 255 writes.
- R11: A `LOW_MARK` of 0 makes `low_water` follow `is_empty`, and a `HIGH_MARK` of 2^AW − 1 makes `high_water` follow `is_full`, each with an elaboration warning. Marks that are out of order or out of range stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push request, active high |
| wr_data | input | DW | Word to push |
| rd_en | input | 1 | Pop request, active high |
| rd_data | output | DW | Registered popped word |
| tst_load | input | 1 | Test load of occupancy and write position |
| tst_count | input | AW | Occupancy value used by the test load |
| is_empty | output | 1 | Occupancy is zero |
| low_water | output | 1 | Occupancy at or below the low mark |
| high_water | output | 1 | Occupancy at or above the high mark |
| is_full | output | 1 | Occupancy at capacity |

## Verification
The hardest case to reach from the ports is showing that storage survives a reset, because a reset empties the FIFO and any later write overwrites the lowest addresses. The stimulus writes ten known words from a clean start, resets, and checks the idle flags. It then uses the load strobe to restore ten words of occupancy and reads the original words back through the normal read path. A second instance built with the marks at the hard limits runs on the same stimulus, and its flags are compared with the empty and full conditions.

// File: rtl/thresh_fifo_pkg.sv
package thresh_fifo_pkg;

  typedef struct packed {
    logic empty;
    logic low;
    logic high;
    logic full;
  } fifo_flags_t;

  function automatic int shape_width(input int sel);
    case (sel)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 9;
      4:       return 18;
      default: return 36;
    endcase
  endfunction

  function automatic int shape_addr_w(input int sel);
    return 13 - sel;
  endfunction

endpackage

// File: rtl/thresh_fifo_ram.sv
module thresh_fifo_ram #(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // array is never reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/thresh_fifo_ctrl.sv
module thresh_fifo_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          full,
  input  logic          empty,
  input  logic          tst_load,
  input  logic [AW-1:0] tst_count,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW:0]   cnt,
  output logic [AW:0]   cnt_nxt
);
  localparam int CW = AW + 1;
  localparam logic [AW:0] CAP = CW'((1 << AW) - 1);

  assign wr_go = wr_en & ~full  & ~tst_load;
  assign rd_go = rd_en & ~empty & ~tst_load;

  always_comb begin
    if (tst_load) cnt_nxt = {1'b0, tst_count};
    else          cnt_nxt = cnt + {{AW{1'b0}}, wr_go} - {{AW{1'b0}}, rd_go};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (tst_load) begin
      wptr <= tst_count;
      rptr <= '0;
      cnt  <= cnt_nxt;
    end else begin
      if (wr_go) wptr <= wptr + 1'b1;
      if (rd_go) rptr <= rptr + 1'b1;
      cnt <= cnt_nxt;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !tst_load) |=> ($stable(cnt) && $stable(wptr)));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en && !tst_load) |=> ($stable(cnt) && $stable(rptr)));

  // R5
  balance_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !full && !empty && !tst_load) |=> $stable(cnt));

  // R8
  cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP);
endmodule

// File: rtl/thresh_fifo_flags.sv
module thresh_fifo_flags
  import thresh_fifo_pkg::*;
#(
  parameter int AW        = 8,
  parameter int LOW_MARK  = 16,
  parameter int HIGH_MARK = 240
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] cnt_nxt,
  output fifo_flags_t flg
);
  localparam int CW = AW + 1;
  localparam logic [AW:0] CAP    = CW'((1 << AW) - 1);
  localparam logic [AW:0] LOW_V  = CW'(LOW_MARK);
  localparam logic [AW:0] HIGH_V = CW'(HIGH_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      flg <= '{empty: 1'b1, low: 1'b1, high: 1'b0, full: 1'b0};
    end else begin
      flg.empty <= (cnt_nxt == '0);
      flg.low   <= (cnt_nxt <= LOW_V);
      flg.high  <= (cnt_nxt >= HIGH_V);
      flg.full  <= (cnt_nxt == CAP);
    end
  end

  // R1
  idle_flags_chk: assert property (@(posedge clk)
    $past(rst) |-> (flg.empty && flg.low && !flg.high && !flg.full));

  // R6
  low_nest_chk: assert property (@(posedge clk) disable iff (rst)
    flg.empty |-> flg.low);

  // R7
  high_nest_chk: assert property (@(posedge clk) disable iff (rst)
    flg.full |-> flg.high);

  // R8
  limits_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flg.empty && flg.full));
endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo
  import thresh_fifo_pkg::*;
#(
  parameter int  SHAPE     = 5,
  parameter int  LOW_MARK  = 16,
  parameter int  HIGH_MARK = 240,
  localparam int DW        = shape_width(SHAPE),
  localparam int AW        = shape_addr_w(SHAPE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          tst_load,
  input  logic [AW-1:0] tst_count,
  output logic          is_empty,
  output logic          low_water,
  output logic          high_water,
  output logic          is_full
);
  localparam int CAP_LVL = (1 << AW) - 1;

  // elaboration-time checks on shape and marks
  if (SHAPE < 0 || SHAPE > 5) begin : g_bad_shape
    $error("thresh_fifo: SHAPE must lie in 0..5");
  end
  if (LOW_MARK < 0 || HIGH_MARK > CAP_LVL || LOW_MARK > HIGH_MARK) begin : g_bad_marks
    $error("thresh_fifo: marks must satisfy 0 <= LOW_MARK <= HIGH_MARK <= capacity");
  end
  if (LOW_MARK == 0) begin : g_low_fallback
    $warning("thresh_fifo: LOW_MARK equals the empty level, low_water tracks is_empty");
  end
  if (HIGH_MARK == CAP_LVL) begin : g_high_fallback
    $warning("thresh_fifo: HIGH_MARK equals capacity, high_water tracks is_full");
  end

  fifo_flags_t   flg;
  logic          wr_go, rd_go;
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt, cnt_nxt;

  thresh_fifo_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .full(flg.full), .empty(flg.empty),
    .tst_load(tst_load), .tst_count(tst_count),
    .wr_go(wr_go), .rd_go(rd_go), .wptr(wptr), .rptr(rptr),
    .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  thresh_fifo_flags #(.AW(AW), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_flags (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .flg(flg)
  );

  thresh_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_go), .waddr(wptr), .wdata(wr_data),
    .re(rd_go), .raddr(rptr), .rdata(rd_data)
  );

  assign is_empty   = flg.empty;
  assign low_water  = flg.low;
  assign high_water = flg.high;
  assign is_full    = flg.full;

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(rd_en && !is_empty && !tst_load)) |=> $stable(rd_data));
endmodule

// File: tb/thresh_fifo_test.sv
module thresh_fifo_test;
  localparam int DW  = 36;
  localparam int AW  = 8;
  localparam int CAP = 255;
  localparam int LOW = 16;
  localparam int HIGH = 240;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, tst_load = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] tst_count = '0;
  logic [DW-1:0] rd_data, fb_rd_data;
  logic          is_empty, low_water, high_water, is_full;
  logic          fb_empty, fb_low, fb_high, fb_full;

  always #4 clk = ~clk;

  thresh_fifo uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .tst_load(tst_load), .tst_count(tst_count),
    .is_empty(is_empty), .low_water(low_water), .high_water(high_water), .is_full(is_full)
  );

  thresh_fifo #(.LOW_MARK(0), .HIGH_MARK(CAP)) uut_fb (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(fb_rd_data), .tst_load(tst_load), .tst_count(tst_count),
    .is_empty(fb_empty), .low_water(fb_low), .high_water(fb_high), .is_full(fb_full)
  );

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] cur_exp = '0;
  bit    mon_en = 1'b0;
  bit    finished = 1'b0;
  string data_req = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and pushes expected read words
  task automatic step(input bit w, input bit r, input logic [DW-1:0] d);
    bit wgo, rgo;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d; tst_load = 1'b0;
    wgo = w && (mq.size() != CAP);
    rgo = r && (mq.size() != 0);
    if (rgo) exp_q.push_back(mq.pop_front());
    if (wgo) mq.push_back(d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0; rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; tst_load = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mq.delete(); exp_q.delete(); cur_exp = '0;
    // R1: idle state after reset
    chk(is_empty == 1'b1, "R1", "is_empty", 64'(is_empty), 64'd1);
    chk(low_water == 1'b1, "R1", "low_water", 64'(low_water), 64'd1);
    chk(high_water == 1'b0, "R1", "high_water", 64'(high_water), 64'd0);
    chk(is_full == 1'b0, "R1", "is_full", 64'(is_full), 64'd0);
    chk(rd_data == '0, "R1", "rd_data", 64'(rd_data), 64'd0);
    mon_en = 1'b1;
  endtask

  // monitor: pops the scoreboard and compares every cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_en) begin
        int n;
        n = mq.size();
        if (exp_q.size() > 0) cur_exp = exp_q.pop_front();
        chk(rd_data == cur_exp, data_req, "rd_data", 64'(rd_data), 64'(cur_exp));
        chk(is_empty == (n == 0), "R8", "is_empty", 64'(is_empty), 64'(n == 0));
        chk(is_full == (n == CAP), "R8", "is_full", 64'(is_full), 64'(n == CAP));
        chk(low_water == (n <= LOW), "R6", "low_water", 64'(low_water), 64'(n <= LOW));
        chk(high_water == (n >= HIGH), "R7", "high_water", 64'(high_water), 64'(n >= HIGH));
        chk(fb_low == (n == 0), "R11", "fallback low_water", 64'(fb_low), 64'(n == 0));
        chk(fb_high == (n == CAP), "R11", "fallback high_water", 64'(fb_high), 64'(n == CAP));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] saved[$];
    logic [DW-1:0] last;
    do_reset();

    // R4: reads on an empty FIFO are ignored
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(rd_data == '0 && is_empty, "R4", "rd_data after empty reads", 64'(rd_data), 64'd0);

    // R2: ordered data with interleaving
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, DW'(36'h0A000 + i));
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0);
    step(1'b1, 1'b1, DW'(36'hB0001));
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    last = cur_exp;
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(rd_data == last, "R4", "rd_data hold on empty read", 64'(rd_data), 64'(last));

    // R5: both strobes at empty, only the write is taken
    step(1'b1, 1'b1, DW'(36'hC0C0));
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(!is_empty && rd_data == last, "R5", "write-only at empty", 64'(is_empty), 64'd0);
    step(1'b0, 1'b1, '0);

    // R10: fill and count the writes to full
    for (int i = 0; i < CAP - 1; i++) step(1'b1, 1'b0, DW'(36'h100000 + i));
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(is_full == 1'b0, "R10", "full after 254 writes", 64'(is_full), 64'd0);
    step(1'b1, 1'b0, DW'(36'h1000FE));
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(is_full == 1'b1, "R10", "full after 255 writes", 64'(is_full), 64'd1);
    chk($bits(rd_data) == 36, "R10", "word width", 64'($bits(rd_data)), 64'd36);

    // R3: writes while full are dropped
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(36'hDEAD0 + i));
    // R5: both strobes at full, only the read is taken
    step(1'b1, 1'b1, DW'(36'hEEEE));
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(is_full == 1'b0, "R5", "read-only at full", 64'(is_full), 64'd0);
    data_req = "R3";
    while (mq.size() > 0) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    data_req = "R2";

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit w, r;
      w = ($urandom % 100) < ((i / 500) % 2 == 0 ? 70 : 35);
      r = ($urandom % 100) < 50;
      step(w, r, DW'({$urandom, $urandom}));
    end
    step(1'b0, 1'b0, '0);

    // R9: storage survives reset and is restored through the test load
    do_reset();
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, DW'(36'h5A0000 + 7 * i));
    step(1'b0, 1'b0, '0);
    saved = mq;
    do_reset();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; tst_load = 1'b1; tst_count = AW'(10);
    mq = saved;
    @(negedge clk);
    tst_load = 1'b0;
    chk(!is_empty && rd_data == '0, "R9", "occupancy restored", 64'(is_empty), 64'd0);
    data_req = "R9";
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(is_empty == 1'b1, "R9", "empty after readback", 64'(is_empty), 64'd1);
    chk(rd_data == saved[9], "R9", "last restored word", 64'(rd_data), 64'(saved[9]));

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule